// File: doc/BRIEF.md
# DAC Sample Word Formatter

This block sits between a parallel sample interface and a DAC core and turns incoming words into 14-bit two's-complement samples. It accepts a sample either as one 14-bit beat (wide mode) or as two consecutive 7-bit beats (narrow mode). Each sample passes through three steps in a fixed order. First, optional bit reversal, whose scope depends on the interface mode. Second, width masking that keeps the upper 14, 12 or 10 bits. Third, an optional offset-binary to two's-complement conversion.

Configuration is written into a 4-bit staging register through a plain write strobe. The block copies it into its working settings only at the start of a sample, so a single sample is never formatted with a mix of old and new settings. The FIFO-bypass mode flag is captured with each sample and reported next to it. It has no effect on the formatting.

Input and output are valid/ready streams. A beat is taken on any cycle where `in_valid` and `in_ready` are both high. A sample is handed on on any cycle where `out_valid` and `out_ready` are both high. The block holds one output sample. `in_ready` is high whenever that slot is empty or is being drained in the same cycle. While `out_ready` is low and a sample is waiting, the input stalls and the waiting sample does not change.

Top module: `dac_sample_formatter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The working settings are: two's-complement input assumed, reversal off, width code 00. A sample sent with no configuration write therefore leaves the block unchanged.
- R2: In wide mode (`narrow_mode`=0), one accepted beat forms one sample. `out_valid` is 1 in the cycle after the clock edge that accepts that beat.
- R3: In narrow mode (`narrow_mode`=1), two accepted beats form one sample. Only `in_data[6:0]` of each beat is used. The first beat supplies sample bits 13:7 and the second supplies bits 6:0. No output appears after the first beat.
- R4: With reversal on (`cfg_wdata[1]`=1) in wide mode, the whole 14-bit word is mirrored: output bit i comes from input bit 13-i.
- R5: With reversal on in narrow mode, each 7-bit beat is mirrored on its own before the two beats are joined.
- R6: The width code `cfg_wdata[3:2]` sets how many low bits are cleared, and the kept bits stay MSB-aligned. Code 00 clears none, 01 clears bits 1:0, and both 10 and 11 clear bits 3:0.
- R7: When `cfg_wdata[0]`=1, the input is already two's complement and passes through unchanged. When it is 0, the input is offset binary and bit 13 is inverted.
- R8: The three steps apply in the order reversal, then masking, then conversion.
- R9: A configuration write takes effect from the next sample that starts after the write. A write between the two beats of a narrow sample does not change that sample.
- R10: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0, and `out_sample` and `out_bypass` hold their values.
- R11: `fifo_bypass` does not change the formatting. `out_bypass` reports the value `fifo_bypass` had when the sample's first beat was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration staging register |
| cfg_wdata | input | 4 | Configuration: [3:2] width code, [1] reverse, [0] two's-complement input |
| narrow_mode | input | 1 | 1: two 7-bit beats per sample, 0: one 14-bit beat |
| fifo_bypass | input | 1 | FIFO-bypass mode flag, carried alongside the sample |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_data | input | 14 | Input beat (narrow mode uses bits 6:0) |
| out_valid | output | 1 | Formatted sample valid |
| out_ready | input | 1 | Downstream takes the sample |
| out_sample | output | 14 | Formatted two's-complement sample |
| out_bypass | output | 1 | Bypass flag captured with this sample |

## Verification
The assertions assume that `narrow_mode` and `fifo_bypass` are steady from one beat acceptance to the next inside a sample. They also assume that the downstream side does not withdraw interest in the middle of a stall. The stimulus changes mode pins only between samples, and it drives all inputs on the falling edge. It keeps `in_valid` low before releasing a stall, so no beat is taken while a held sample is checked. The sweep covers every configuration code in both interface modes and both bypass values, with edge-pattern and varied data.

// File: rtl/dac_fmt_pkg.sv
package dac_fmt_pkg;

  // Working settings for one sample; bit layout matches the write port.
  typedef struct packed {
    logic [1:0] width;   // 00 all, 01 drop 2 LSBs, 1x drop 4 LSBs
    logic       rev;     // mirror bits
    logic       twos;    // 1: input already two's complement
  } fmt_cfg_t;

  localparam fmt_cfg_t CFG_RESET = '{width: 2'b00, rev: 1'b0, twos: 1'b1};

endpackage

// File: rtl/fmt_pack.sv
module fmt_pack
  import dac_fmt_pkg::*;
#(
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  fmt_cfg_t          cfg_wdata,
  input  logic              narrow_mode,
  input  logic              fifo_bypass,
  input  logic              accept,
  input  logic [WORD_W-1:0] in_data,
  output logic [WORD_W-1:0] word,
  output fmt_cfg_t          cur_cfg,
  output logic              cur_narrow,
  output logic              cur_bypass,
  output logic              load
);
  localparam int HALF_W = WORD_W / 2;

  fmt_cfg_t          pend_cfg, act_cfg;
  logic              act_narrow, act_bypass;
  logic              phase;            // 1: upper half held, waiting for lower
  logic [HALF_W-1:0] hi_half;

  assign cur_cfg    = phase ? act_cfg    : pend_cfg;
  assign cur_narrow = phase ? act_narrow : narrow_mode;
  assign cur_bypass = phase ? act_bypass : fifo_bypass;
  assign word       = phase ? {hi_half, in_data[HALF_W-1:0]} : in_data;
  assign load       = accept && (phase || !narrow_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_cfg   <= CFG_RESET;
      act_cfg    <= CFG_RESET;
      act_narrow <= 1'b0;
      act_bypass <= 1'b0;
      phase      <= 1'b0;
      hi_half    <= '0;
    end else begin
      if (cfg_wr) pend_cfg <= cfg_wdata;
      if (accept && !phase) begin
        act_cfg    <= pend_cfg;
        act_narrow <= narrow_mode;
        act_bypass <= fifo_bypass;
        if (narrow_mode) begin
          hi_half <= in_data[HALF_W-1:0];
          phase   <= 1'b1;
        end
      end else if (accept && phase) begin
        phase <= 1'b0;
      end
    end
  end

  // First narrow beat must open a pairing window, never emit a sample.
  assert_first_half_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !phase && narrow_mode) |=> (phase && !$past(load)));

  // Settings in use cannot move while a sample is half assembled.
  assert_cfg_frozen_mid_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    phase |=> $stable(act_cfg));

endmodule

// File: rtl/fmt_core.sv
module fmt_core
  import dac_fmt_pkg::*;
#(
  parameter int WORD_W   = 14,
  parameter int DROP_MID = 2,
  parameter int DROP_LOW = 4
) (
  input  logic [WORD_W-1:0] word,
  input  logic              narrow,
  input  fmt_cfg_t          cfg,
  output logic [WORD_W-1:0] result
);
  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] rev_full, rev_half, ordered, keep, masked;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    localparam bit KEEP_MID = (i >= DROP_MID);
    localparam bit KEEP_LOW = (i >= DROP_LOW);
    assign rev_full[i] = word[WORD_W-1-i];
    if (i < HALF_W) begin : g_lo
      assign rev_half[i] = word[HALF_W-1-i];
    end else begin : g_hi
      assign rev_half[i] = word[WORD_W-1-(i-HALF_W)];
    end
    assign keep[i] = (cfg.width == 2'b00)
                   | ((cfg.width == 2'b01) & KEEP_MID)
                   | (cfg.width[1] & KEEP_LOW);
  end

  assign ordered = cfg.rev ? (narrow ? rev_half : rev_full) : word;
  assign masked  = ordered & keep;
  assign result  = masked ^ {~cfg.twos, {(WORD_W-1){1'b0}}};

endmodule

// File: rtl/fmt_out.sv
module fmt_out #(
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] result,
  input  logic              bypass_in,
  input  logic              out_ready,
  output logic              can_take,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_sample,
  output logic              out_bypass
);
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
      out_bypass <= 1'b0;
    end else if (load) begin
      out_valid  <= 1'b1;
      out_sample <= result;
      out_bypass <= bypass_in;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) && $stable(out_bypass)));

endmodule

// File: rtl/dac_sample_formatter.sv
module dac_sample_formatter
  import dac_fmt_pkg::*;
#(
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_wdata,
  input  logic              narrow_mode,
  input  logic              fifo_bypass,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_sample,
  output logic              out_bypass
);
  logic              accept, load, cur_narrow, cur_bypass;
  logic [WORD_W-1:0] word, result;
  fmt_cfg_t          cur_cfg;

  assign accept = in_valid && in_ready;

  fmt_pack #(.WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(fmt_cfg_t'(cfg_wdata)),
    .narrow_mode(narrow_mode), .fifo_bypass(fifo_bypass), .accept(accept),
    .in_data(in_data), .word(word), .cur_cfg(cur_cfg), .cur_narrow(cur_narrow),
    .cur_bypass(cur_bypass), .load(load)
  );

  fmt_core #(.WORD_W(WORD_W)) u_core (
    .word(word), .narrow(cur_narrow), .cfg(cur_cfg), .result(result)
  );

  fmt_out #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .result(result), .bypass_in(cur_bypass),
    .out_ready(out_ready), .can_take(in_ready), .out_valid(out_valid),
    .out_sample(out_sample), .out_bypass(out_bypass)
  );

  assert_valid_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  assert_ready_when_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

// File: tb/test_dac_sample_formatter.sv
module test_dac_sample_formatter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_wdata = 4'h0;
  logic        narrow_mode = 1'b0;
  logic        fifo_bypass = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [13:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [13:0] out_sample;
  logic        out_bypass;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;   // 125 MHz

  dac_sample_formatter i_dac_sample_formatter (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .narrow_mode(narrow_mode), .fifo_bypass(fifo_bypass), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_sample(out_sample), .out_bypass(out_bypass)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] model(input logic [13:0] d, input logic [3:0] c, input bit nar);
    logic [13:0] w;
    w = d;
    if (c[1]) begin
      for (int i = 0; i < 7; i++) begin
        if (nar) begin
          w[i]     = d[6-i];
          w[7+i]   = d[13-i];
        end else begin
          w[i]     = d[13-i];
          w[13-i]  = d[i];
        end
      end
    end
    case (c[3:2])
      2'b00:   w = w;
      2'b01:   w = w & 14'h3FFC;
      default: w = w & 14'h3FF0;
    endcase
    if (!c[0]) w[13] = ~w[13];
    return w;
  endfunction

  task automatic write_cfg(input logic [3:0] c);
    cfg_wr = 1'b1; cfg_wdata = c;
    @(posedge clk); @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Called at a falling edge; returns at the falling edge after the last accept.
  task automatic send_sample(input logic [13:0] d, input bit nar, input bit byp, output bit early);
    narrow_mode = nar; fifo_bypass = byp;
    early = 1'b0;
    in_valid = 1'b1;
    if (nar) begin
      in_data = {~d[6:0], d[13:7]};
      @(posedge clk); @(negedge clk);
      early = out_valid;
      in_data = {d[13:7] ^ 7'h55, d[6:0]};
    end else begin
      in_data = d;
    end
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit early;
    logic [13:0] d, exp;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    // Defaults: two's complement, no reversal, full width.
    send_sample(14'h2123, 1'b0, 1'b0, early);
    check(out_valid == 1'b1, "R2 valid one cycle after accept", out_valid, 1);
    check(out_sample == 14'h2123, "R1 default settings pass-through", out_sample, 14'h2123);
    @(negedge clk);
    check(out_valid == 1'b0, "R2 valid drops after handoff", out_valid, 0);

    // Full sweep: every config code, both modes, both bypass values.
    for (int c = 0; c < 16; c++) begin
      write_cfg(c[3:0]);
      for (int nar = 0; nar < 2; nar++) begin
        for (int byp = 0; byp < 2; byp++) begin
          for (int k = 0; k < 6; k++) begin
            case (k)
              0: d = 14'h3FFF;
              1: d = 14'h0000;
              2: d = 14'h2AAA;
              3: d = 14'h0001;
              4: d = 14'h2000;
              default: d = 14'((c * 37 + nar * 911 + byp * 4093 + 1234) & 16'h3FFF);
            endcase
            exp = model(d, c[3:0], nar[0]);
            send_sample(d, nar[0], byp[0], early);
            if (nar[0]) check(early == 1'b0, "R3 no output after first half", early, 0);
            check(out_valid == 1'b1, "R2 R3 sample completes", out_valid, 1);
            check(out_sample == exp, "R4 R5 R6 R7 R8 formatted sample", out_sample, exp);
            check(out_bypass == byp[0], "R11 bypass flag carried", out_bypass, byp);
            @(negedge clk);
          end
        end
      end
    end

    // Config change between two narrow beats.
    write_cfg(4'b0000);
    narrow_mode = 1'b1; fifo_bypass = 1'b0;
    d = 14'h1234;
    in_valid = 1'b1; in_data = {7'h00, d[13:7]};
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    write_cfg(4'b0101);
    in_valid = 1'b1; in_data = {7'h7F, d[6:0]};
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    exp = model(d, 4'b0000, 1'b1);
    check(out_sample == exp, "R9 mid-sample write ignored", out_sample, exp);
    @(negedge clk);
    send_sample(14'h0ABF, 1'b0, 1'b0, early);
    exp = model(14'h0ABF, 4'b0101, 1'b0);
    check(out_sample == exp, "R9 write applies to next sample", out_sample, exp);
    @(negedge clk);

    // Back-pressure.
    write_cfg(4'b0001);
    out_ready = 1'b0;
    send_sample(14'h1A5C, 1'b0, 1'b1, early);
    in_valid = 1'b1; in_data = 14'h0F0F;
    for (int s = 0; s < 3; s++) begin
      check(out_valid == 1'b1, "R10 valid held in stall", out_valid, 1);
      check(in_ready == 1'b0, "R10 input stalled", in_ready, 0);
      check(out_sample == 14'h1A5C, "R10 sample held in stall", out_sample, 14'h1A5C);
      check(out_bypass == 1'b1, "R10 bypass held in stall", out_bypass, 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 stall released", out_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule